// File: doc/BRIEF.md
# Dual-Chamber Pacing Timing Core

This block is the timing heart of a dual-chamber pacing controller. A 1 ms strobe drives it. It takes raw detection pulses from an atrial channel and a ventricular channel. It filters them into qualified events: atrial sense, atrial refractory sense and ventricular sense. It also decides when to deliver an atrial or a ventricular pace. Five interval timers run together. The lower rate interval bounds the longest ventricular cycle. The atrio-ventricular delay ties each ventricular pace to its atrial event. The upper rate interval bounds how fast the ventricle may be paced. The post-ventricular atrial blanking and refractory windows qualify atrial detections. The ventricular refractory window suppresses early ventricular detections.

Two saturating millisecond counters hold all the timing state. One measures time since the last ventricular event and the other measures time since the last atrial event. The blanking, refractory, lower-rate and upper-rate decisions are comparisons against the ventricular counter. The atrio-ventricular decision compares the atrial counter. The interval values sit in registers that are loaded from parameters at reset. A ventricular pace that becomes due early is held, and it is released on the tick at which the upper rate interval completes.

Top module: `pace_timing_core`

## Requirements
- R1: While rst_ni is low, and after reset until an interval completes, all five event outputs are 0. Reset acts as a ventricular event: time since the last ventricular event starts at 0.
- R2: Elapsed time counts the ticks after an event's cycle, including the current cycle's tick. If no atrial event has occurred since the last ventricular event, ap_o pulses in the cycle where elapsed ventricular time reaches lower rate minus AV delay (default 1000-150 = 850).
- R3: After an atrial sense or atrial pace, vp_o pulses in the cycle where elapsed atrial time reaches the AV delay (default 150), provided the upper-rate condition also holds.
- R4: A ventricular sense cancels a pending ventricular pace and restarts the lower-rate timing, so the next atrial pace comes 850 ticks after that sense.
- R5: A ventricular pace that becomes due before 400 ticks of ventricular time is held. It pulses in the cycle where elapsed ventricular time reaches 400.
- R6: An atrial detection with elapsed ventricular time below 50 produces no output and has no effect on timing.
- R7: An atrial detection with elapsed ventricular time from 50 up to but not including 100 pulses ar_o only and starts no AV delay. From 100 onward it pulses as_o and starts the AV delay.
- R8: A ventricular detection with elapsed ventricular time below 150 is ignored and does not restart timing. At 150 it is accepted as vs_o.
- R9: Every event output is high for exactly one cycle per event.
- R10: When a detection and a pace expiry fall in the same cycle, the sensed event is reported and the pace is withheld.
- R11: Timers advance only in cycles with tick_i high. Cycles without a tick add no elapsed time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; loads timing registers |
| tick_i | input | 1 | 1 ms strobe, one cycle wide |
| atr_det_i | input | 1 | Raw atrial detection pulse |
| ven_det_i | input | 1 | Raw ventricular detection pulse |
| as_o | output | 1 | Atrial sense event |
| ar_o | output | 1 | Atrial refractory sense event |
| vs_o | output | 1 | Ventricular sense event |
| ap_o | output | 1 | Atrial pace |
| vp_o | output | 1 | Ventricular pace |

## Verification
Sense outputs are combinational from the detection input, so they appear in the same cycle the detection is driven. Pace outputs appear in the cycle whose tick completes the interval, which is N cycles after the referenced event's cycle when the tick is high every cycle. The bench keeps a free-running cycle index. At each falling edge it records the index of every output pulse. It schedules detections at exact offsets from a recorded ventricular event, and each check compares recorded indices against these offsets. In the tick-gating scenario the expected offset grows by the number of cycles without a tick.

// File: rtl/pace_pkg.sv
package pace_pkg;
  parameter int unsigned MS_W = 12;
  typedef logic [MS_W-1:0] ms_t;
  typedef struct packed {
    ms_t avi;
    ms_t lri;
    ms_t pvarp;
    ms_t pvab;
    ms_t vrp;
    ms_t uri;
  } pace_cfg_t;
endpackage

// File: rtl/pace_ms_timer.sv
module pace_ms_timer #(
  parameter int unsigned W = pace_pkg::MS_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         run_i,
  output logic [W-1:0] el_o
);
  localparam logic [W-1:0] CntMax = '1;

  logic [W-1:0] cnt_q;
  logic         step;

  // saturate rather than wrap
  assign step = run_i & tick_i & (cnt_q != CntMax);
  assign el_o = step ? cnt_q + W'(1) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/pace_sense_filter.sv
module pace_sense_filter
  import pace_pkg::*;
(
  input  logic atr_det_i,
  input  logic ven_det_i,
  input  ms_t  el_v_i,
  input  ms_t  pvab_i,
  input  ms_t  pvarp_i,
  input  ms_t  vrp_i,
  output logic as_o,
  output logic ar_o,
  output logic vs_o
);
  logic in_blank, in_arefr, in_vrefr;

  assign in_blank = el_v_i < pvab_i;
  assign in_arefr = el_v_i < pvarp_i;
  assign in_vrefr = el_v_i < vrp_i;

  assign as_o = atr_det_i & ~in_arefr;
  assign ar_o = atr_det_i & in_arefr & ~in_blank;
  assign vs_o = ven_det_i & ~in_vrefr;
endmodule

// File: rtl/pace_pace_ctrl.sv
module pace_pace_ctrl
  import pace_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic as_i,
  input  logic vs_i,
  input  ms_t  el_v_i,
  input  ms_t  el_a_i,
  input  ms_t  avi_i,
  input  ms_t  lri_i,
  input  ms_t  uri_i,
  output logic ap_o,
  output logic vp_o,
  output logic av_run_o
);
  logic av_q;
  ms_t  va_lim;
  logic vp_due;

  assign va_lim = lri_i - avi_i;
  assign vp_due = av_q & (el_a_i >= avi_i);

  // sensed events win ties; held vp waits for upper-rate expiry
  assign ap_o = tick_i & ~av_q & ~as_i & (el_v_i >= va_lim);
  assign vp_o = tick_i & vp_due & ~vs_i & (el_v_i >= uri_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               av_q <= 1'b0;
    else if (as_i | ap_o)      av_q <= 1'b1;
    else if (vs_i | vp_o)      av_q <= 1'b0;
  end

  assign av_run_o = av_q;
endmodule

// File: rtl/pace_timing_core.sv
module pace_timing_core
  import pace_pkg::*;
#(
  parameter ms_t AVI_MS   = 12'd150,
  parameter ms_t LRI_MS   = 12'd1000,
  parameter ms_t PVARP_MS = 12'd100,
  parameter ms_t PVAB_MS  = 12'd50,
  parameter ms_t VRP_MS   = 12'd150,
  parameter ms_t URI_MS   = 12'd400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic atr_det_i,
  input  logic ven_det_i,
  output logic as_o,
  output logic ar_o,
  output logic vs_o,
  output logic ap_o,
  output logic vp_o
);
  pace_cfg_t cfg_q;
  ms_t       el_v, el_a;
  logic      as_ev, ar_ev, vs_ev, ap_ev, vp_ev, av_run;
  logic      v_evt, a_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.avi   <= AVI_MS;
      cfg_q.lri   <= LRI_MS;
      cfg_q.pvarp <= PVARP_MS;
      cfg_q.pvab  <= PVAB_MS;
      cfg_q.vrp   <= VRP_MS;
      cfg_q.uri   <= URI_MS;
    end else begin
      cfg_q <= cfg_q;
    end
  end

  assign v_evt = vs_ev | vp_ev;
  assign a_evt = as_ev | ap_ev;

  pace_ms_timer #(.W(MS_W)) u_v_tmr (
    .clk_i, .rst_ni, .tick_i,
    .clr_i (v_evt),
    .run_i (1'b1),
    .el_o  (el_v)
  );

  pace_ms_timer #(.W(MS_W)) u_a_tmr (
    .clk_i, .rst_ni, .tick_i,
    .clr_i (a_evt),
    .run_i (av_run),
    .el_o  (el_a)
  );

  pace_sense_filter u_sense (
    .atr_det_i, .ven_det_i,
    .el_v_i  (el_v),
    .pvab_i  (cfg_q.pvab),
    .pvarp_i (cfg_q.pvarp),
    .vrp_i   (cfg_q.vrp),
    .as_o    (as_ev),
    .ar_o    (ar_ev),
    .vs_o    (vs_ev)
  );

  pace_pace_ctrl u_pace (
    .clk_i, .rst_ni, .tick_i,
    .as_i     (as_ev),
    .vs_i     (vs_ev),
    .el_v_i   (el_v),
    .el_a_i   (el_a),
    .avi_i    (cfg_q.avi),
    .lri_i    (cfg_q.lri),
    .uri_i    (cfg_q.uri),
    .ap_o     (ap_ev),
    .vp_o     (vp_ev),
    .av_run_o (av_run)
  );

  assign as_o = as_ev;
  assign ar_o = ar_ev;
  assign vs_o = vs_ev;
  assign ap_o = ap_ev;
  assign vp_o = vp_ev;
endmodule

// File: rtl/pace_timing_chk.sv
module pace_timing_chk #(
  parameter int unsigned LRI_MS  = 1000,
  parameter int unsigned PVAB_MS = 50,
  parameter int unsigned VRP_MS  = 150,
  parameter int unsigned URI_MS  = 400
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic as_o,
  input logic ar_o,
  input logic vs_o,
  input logic ap_o,
  input logic vp_o
);
  logic [15:0] cnt_q;
  logic [15:0] el;

  // independent model of ticks since last ventricular output
  assign el = (tick_i && cnt_q != 16'hFFFF) ? cnt_q + 16'd1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (vs_o | vp_o) cnt_q <= '0;
    else                  cnt_q <= el;
  end

  a_r2_lower_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(el) <= LRI_MS);
  a_r5_upper_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vp_o |-> 32'(el) >= URI_MS);
  a_r6_blanking: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_o | ar_o) |-> 32'(el) >= PVAB_MS);
  a_r8_vrefr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_o |-> 32'(el) >= VRP_MS);
  a_r7_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(as_o && ar_o));
  a_r10_tie_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(as_o && ap_o));
  a_r10_tie_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vs_o && vp_o));
  a_r9_ap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_o |=> !ap_o);
  a_r9_vp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vp_o |=> !vp_o);
endmodule

bind pace_timing_core pace_timing_chk #(
  .LRI_MS (32'(LRI_MS)),
  .PVAB_MS(32'(PVAB_MS)),
  .VRP_MS (32'(VRP_MS)),
  .URI_MS (32'(URI_MS))
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick_i(tick_i),
  .as_o  (as_o),
  .ar_o  (ar_o),
  .vs_o  (vs_o),
  .ap_o  (ap_o),
  .vp_o  (vp_o)
);

// File: tb/tb_pace_timing_core.sv
`timescale 1ns/1ps
module tb_pace_timing_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic atr_det = 1'b0;
  logic ven_det = 1'b0;
  logic as_w, ar_w, vs_w, ap_w, vp_w;

  always #2.5 clk = ~clk;

  pace_timing_core dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .atr_det_i(atr_det), .ven_det_i(ven_det),
    .as_o(as_w), .ar_o(ar_w), .vs_o(vs_w), .ap_o(ap_w), .vp_o(vp_w)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_as = 0, n_ar = 0, n_vs = 0, n_ap = 0, n_vp = 0, n_v = 0, n_wide = 0;
  longint t_as = -1, t_ar = -1, t_vs = -1, t_ap = -1, t_vp = -1, t_v = -1;
  logic p_as = 0, p_ar = 0, p_vs = 0, p_ap = 0, p_vp = 0;
  int n_chk = 0, n_fail = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (as_w) begin n_as++; t_as = cyc; end
      if (ar_w) begin n_ar++; t_ar = cyc; end
      if (vs_w) begin n_vs++; t_vs = cyc; n_v++; t_v = cyc; end
      if (ap_w) begin n_ap++; t_ap = cyc; end
      if (vp_w) begin n_vp++; t_vp = cyc; n_v++; t_v = cyc; end
      if ((as_w && p_as) || (ar_w && p_ar) || (vs_w && p_vs) ||
          (ap_w && p_ap) || (vp_w && p_vp)) n_wide++;
      p_as = as_w; p_ar = ar_w; p_vs = vs_w; p_ap = ap_w; p_vp = vp_w;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic at_cycle(input longint target);
    while (cyc < target) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_atr(input longint target);
    at_cycle(target);
    atr_det = 1'b1;
    @(posedge clk); #1 atr_det = 1'b0;
  endtask

  task automatic pulse_ven(input longint target);
    at_cycle(target);
    ven_det = 1'b1;
    @(posedge clk); #1 ven_det = 1'b0;
  endtask

  task automatic wait_v(output longint t);
    int n;
    n = n_v;
    while (n_v == n) begin @(negedge clk); #1; end
    t = t_v;
  endtask

  task automatic t_reset;
    repeat (5) begin
      @(negedge clk);
      chk({as_w, ar_w, vs_w, ap_w, vp_w} == 5'b0, "R1", "outputs in reset",
          {as_w, ar_w, vs_w, ap_w, vp_w}, 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    chk(n_as + n_ar + n_vs + n_ap + n_vp == 0, "R1", "events after reset",
        n_as + n_ar + n_vs + n_ap + n_vp, 0);
  endtask

  task automatic t_idle;
    longint t0; int s_as;
    wait_v(t0); s_as = n_as;
    at_cycle(t0 + 1100);
    chk(t_ap == t0 + 850, "R2", "ap after v", t_ap - t0, 850);
    chk(t_vp == t0 + 1000, "R3", "vp after ap", t_vp - t0, 1000);
    chk(n_as == s_as, "R2", "no spurious as", n_as - s_as, 0);
  endtask

  task automatic t_as_track;
    longint t0; int s_ap;
    wait_v(t0); s_ap = n_ap;
    pulse_atr(t0 + 300);
    at_cycle(t0 + 500);
    chk(t_as == t0 + 300, "R7", "as outside refractory", t_as - t0, 300);
    chk(t_vp == t0 + 450, "R3", "vp after as", t_vp - t0, 450);
    chk(n_ap == s_ap, "R2", "ap inhibited by as", n_ap - s_ap, 0);
  endtask

  task automatic t_vs_inhibit;
    longint t0; int s_vp;
    wait_v(t0); s_vp = n_vp;
    pulse_atr(t0 + 300);
    pulse_ven(t0 + 400);
    at_cycle(t0 + 1300);
    chk(t_vs == t0 + 400, "R4", "vs reported", t_vs - t0, 400);
    chk(n_vp == s_vp, "R4", "vp cancelled", n_vp - s_vp, 0);
    chk(t_ap == t0 + 1250, "R4", "lri restart", t_ap - t0, 1250);
  endtask

  task automatic t_uri;
    longint t0;
    wait_v(t0);
    pulse_atr(t0 + 120);
    at_cycle(t0 + 450);
    chk(t_as == t0 + 120, "R5", "early as", t_as - t0, 120);
    chk(t_vp == t0 + 400, "R5", "vp held to uri", t_vp - t0, 400);
  endtask

  task automatic t_blank;
    longint t0; int s_as, s_ar;
    wait_v(t0); s_as = n_as; s_ar = n_ar;
    pulse_atr(t0 + 30);
    pulse_atr(t0 + 49);
    at_cycle(t0 + 900);
    chk(n_as + n_ar == s_as + s_ar, "R6", "blanked detections",
        n_as + n_ar - s_as - s_ar, 0);
    chk(t_ap == t0 + 850, "R6", "timing unaffected", t_ap - t0, 850);
  endtask

  task automatic t_refr;
    longint t0; int s_as, s_ar;
    wait_v(t0); s_as = n_as; s_ar = n_ar;
    pulse_atr(t0 + 50);
    pulse_atr(t0 + 99);
    at_cycle(t0 + 900);
    chk(n_ar == s_ar + 2, "R7", "ar count", n_ar - s_ar, 2);
    chk(t_ar == t0 + 99, "R7", "ar at 99", t_ar - t0, 99);
    chk(n_as == s_as, "R7", "no as in refractory", n_as - s_as, 0);
    chk(t_ap == t0 + 850, "R7", "ar starts no av", t_ap - t0, 850);
    wait_v(t0);
    pulse_atr(t0 + 100);
    at_cycle(t0 + 420);
    chk(t_as == t0 + 100, "R7", "as at boundary", t_as - t0, 100);
    chk(t_vp == t0 + 400, "R7", "as starts av", t_vp - t0, 400);
  endtask

  task automatic t_vrp;
    longint t0; int s_vs;
    wait_v(t0); s_vs = n_vs;
    pulse_ven(t0 + 100);
    pulse_ven(t0 + 149);
    at_cycle(t0 + 900);
    chk(n_vs == s_vs, "R8", "vs ignored in refractory", n_vs - s_vs, 0);
    chk(t_ap == t0 + 850, "R8", "no restart", t_ap - t0, 850);
    wait_v(t0);
    pulse_ven(t0 + 150);
    at_cycle(t0 + 1050);
    chk(t_vs == t0 + 150, "R8", "vs at boundary", t_vs - t0, 150);
    chk(t_ap == t0 + 1000, "R8", "restart from vs", t_ap - t0, 1000);
  endtask

  task automatic t_tie;
    longint t0; int s_ap, s_vp;
    wait_v(t0); s_ap = n_ap;
    pulse_atr(t0 + 850);
    at_cycle(t0 + 1050);
    chk(t_as == t0 + 850, "R10", "as wins over ap", t_as - t0, 850);
    chk(n_ap == s_ap, "R10", "ap withheld", n_ap - s_ap, 0);
    chk(t_vp == t0 + 1000, "R10", "vp after tied as", t_vp - t0, 1000);
    wait_v(t0); s_vp = n_vp;
    pulse_ven(t0 + 1000);
    at_cycle(t0 + 1010);
    chk(t_vs == t0 + 1000, "R10", "vs wins over vp", t_vs - t0, 1000);
    chk(n_vp == s_vp, "R10", "vp withheld", n_vp - s_vp, 0);
  endtask

  task automatic t_tick;
    longint t0; int s_ap;
    wait_v(t0); s_ap = n_ap;
    at_cycle(t0 + 1); tick = 1'b0;
    at_cycle(t0 + 201); tick = 1'b1;
    at_cycle(t0 + 1100);
    chk(t_ap == t0 + 1050, "R11", "ap delayed by idle ticks", t_ap - t0, 1050);
    chk(n_ap == s_ap + 1, "R11", "single ap", n_ap - s_ap, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    t_idle;
    t_as_track;
    t_vs_inhibit;
    t_uri;
    t_blank;
    t_refr;
    t_vrp;
    t_tie;
    t_tick;
    chk(n_wide == 0, "R9", "multi-cycle pulses", n_wide, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule